// File: doc/BRIEF.md
# Move-to-Front Translation Buffer

A small fully associative translation buffer that keeps its slots in physical recency order, slot 0 being the most recently used. A lookup presents a virtual page number and a context identifier. The block compares them against every slot at once and returns, in the same cycle, a hit flag, the slot position that matched and the stored physical frame.

When a hit lands beyond a small protected front window, the entry moves to slot 0 at the next clock edge. Every entry that was ahead of it moves one slot back. A hit inside the window changes nothing. An insert always places the new translation in slot 0 and pushes the whole list back by one slot, which discards whatever sat in the last slot. A flush empties the buffer. Replacement therefore needs no age counters and no pointer: the last slot always holds the victim.

Top module: `mtf_tlb`

## Requirements
- R1: `hit` is 1 only while `lookupValid` is 1 and some slot holding a valid entry matches both `lookupVpn` and `lookupCtx`. With `lookupValid` at 0, `hit` is 0.
- R2: When several slots match, the lowest-numbered one wins. `hitIdx` gives that slot's position as it is before any reordering, and `hitPfn` gives its frame.
- R3: A hit at a position less than or equal to `WINDOW` (default 1) leaves the order of all slots unchanged.
- R4: A hit at a position p greater than `WINDOW` moves the entry to slot 0 at the next rising edge. The entries in slots 0 to p-1 each move back one slot, and slots beyond p are unchanged.
- R5: On a reordering hit, `hitPfn` is the frame of the entry that will occupy slot 0 after the edge.
- R6: An insert (`insValid`=1) moves every slot back by one, drops the last slot whether or not it is valid, and writes the new translation into slot 0. No search for a free slot is made.
- R7: A flush invalidates every slot, so lookups miss until new inserts arrive.
- R8: If an insert and a reordering hit occur in the same cycle, the insert is performed and the reorder is dropped.
- R9: A flush in the same cycle as an insert or a reordering hit takes priority, and neither of the other two takes effect.
- R10: After reset every slot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| lookupCtx | input | CTX_W | Context identifier of the lookup |
| hit | output | 1 | Lookup matched a valid entry |
| hitIdx | output | $clog2(DEPTH) | Position of the matching slot before any reorder |
| hitPfn | output | PFN_W | Physical frame of the matching entry |
| insValid | input | 1 | Insert a new translation at the next edge |
| insVpn | input | VPN_W | Virtual page of the new translation |
| insCtx | input | CTX_W | Context identifier of the new translation |
| insPfn | input | PFN_W | Physical frame of the new translation |
| flush | input | 1 | Invalidate every slot at the next edge |

## Verification
The hardest cases to reach from the ports are a reordering hit that meets an insert or a flush in the same cycle, and a lookup whose key is present in more than one slot. Random stimulus draws keys from a deliberately tiny space of pages and contexts, so duplicate entries and deep hits occur often. Directed sequences first fill the buffer with known keys, and then collide a deep hit with an insert and with a flush. A bench model tracks the slot order, so the hit position of each later lookup shows whether the reorder was dropped or carried out.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic flushAll;
    logic doInsert;
    logic doPromote;
  } mtf_strobe_t;
endpackage

// File: rtl/mtf_ctrl.sv
module mtf_ctrl
  import mtf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WINDOW = 1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             insValid,
  input  logic             hit,
  input  logic [IDX_W-1:0] hitIdx,
  output mtf_strobe_t      strobes
);
  logic deepHit;

  always_comb begin
    deepHit           = hit && (int'(hitIdx) > WINDOW);
    strobes.flushAll  = flush;
    strobes.doInsert  = insValid && !flush;
    strobes.doPromote = deepHit && !insValid && !flush;
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.flushAll, strobes.doInsert, strobes.doPromote}));

  // R8
  insert_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insValid |-> !strobes.doPromote);
endmodule

// File: rtl/mtf_store.sv
module mtf_store
  import mtf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int VPN_W  = 20,
  parameter int CTX_W  = 8,
  parameter int PFN_W  = 20,
  parameter int WINDOW = 1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mtf_strobe_t      strobes,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [CTX_W-1:0] lookupCtx,
  input  logic [VPN_W-1:0] insVpn,
  input  logic [CTX_W-1:0] insCtx,
  input  logic [PFN_W-1:0] insPfn,
  output logic             hit,
  output logic [IDX_W-1:0] hitIdx,
  output logic [PFN_W-1:0] hitPfn
);
  logic [DEPTH-1:0]            slotValid;
  logic [DEPTH-1:0][VPN_W-1:0] slotVpn;
  logic [DEPTH-1:0][CTX_W-1:0] slotCtx;
  logic [DEPTH-1:0][PFN_W-1:0] slotPfn;
  logic [DEPTH-1:0]            matchVec;
  logic                        anyMatch;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign matchVec[g] = slotValid[g] && (slotVpn[g] == lookupVpn) &&
                         (slotCtx[g] == lookupCtx);
  end

  // Lowest slot wins: scan from the back so the front overwrites.
  always_comb begin
    anyMatch = 1'b0;
    hitIdx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch = 1'b1;
        hitIdx   = IDX_W'(i);
      end
    end
    hit    = lookupValid && anyMatch;
    hitPfn = slotPfn[hitIdx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.flushAll) begin
      slotValid <= '0;
      slotVpn   <= '0;
      slotCtx   <= '0;
      slotPfn   <= '0;
    end else if (strobes.doInsert) begin
      for (int i = 1; i < DEPTH; i++) begin
        slotValid[i] <= slotValid[i-1];
        slotVpn[i]   <= slotVpn[i-1];
        slotCtx[i]   <= slotCtx[i-1];
        slotPfn[i]   <= slotPfn[i-1];
      end
      slotValid[0] <= 1'b1;
      slotVpn[0]   <= insVpn;
      slotCtx[0]   <= insCtx;
      slotPfn[0]   <= insPfn;
    end else if (strobes.doPromote) begin
      for (int i = 1; i < DEPTH; i++) begin
        if (i <= int'(hitIdx)) begin
          slotValid[i] <= slotValid[i-1];
          slotVpn[i]   <= slotVpn[i-1];
          slotCtx[i]   <= slotCtx[i-1];
          slotPfn[i]   <= slotPfn[i-1];
        end
      end
      slotValid[0] <= slotValid[hitIdx];
      slotVpn[0]   <= slotVpn[hitIdx];
      slotCtx[0]   <= slotCtx[hitIdx];
      slotPfn[0]   <= slotPfn[hitIdx];
    end
  end

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.flushAll |=> (slotValid == '0));

  // R6
  insert_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.doInsert |=> slotValid[0] && (slotVpn[0] == $past(insVpn)) &&
      (slotPfn[0] == $past(insPfn)) &&
      (slotVpn[DEPTH-1] == $past(slotVpn[DEPTH-2])));

  // R5
  promote_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.doPromote |=> slotValid[0] && (slotPfn[0] == $past(hitPfn)) &&
      (slotVpn[0] == $past(lookupVpn)));

  // R3
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && int'(hitIdx) <= WINDOW && !strobes.flushAll && !strobes.doInsert)
      |=> $stable(slotVpn) && $stable(slotValid) && $stable(slotPfn));
endmodule

// File: rtl/mtf_tlb.sv
module mtf_tlb
  import mtf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int VPN_W  = 20,
  parameter int CTX_W  = 8,
  parameter int PFN_W  = 20,
  parameter int WINDOW = 1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [CTX_W-1:0] lookupCtx,
  output logic             hit,
  output logic [IDX_W-1:0] hitIdx,
  output logic [PFN_W-1:0] hitPfn,
  input  logic             insValid,
  input  logic [VPN_W-1:0] insVpn,
  input  logic [CTX_W-1:0] insCtx,
  input  logic [PFN_W-1:0] insPfn,
  input  logic             flush
);
  mtf_strobe_t strobes;

  mtf_ctrl #(.DEPTH(DEPTH), .WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .insValid(insValid),
    .hit(hit), .hitIdx(hitIdx), .strobes(strobes)
  );

  mtf_store #(.DEPTH(DEPTH), .VPN_W(VPN_W), .CTX_W(CTX_W), .PFN_W(PFN_W),
              .WINDOW(WINDOW)) u_store (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn), .lookupCtx(lookupCtx),
    .insVpn(insVpn), .insCtx(insCtx), .insPfn(insPfn),
    .hit(hit), .hitIdx(hitIdx), .hitPfn(hitPfn)
  );
endmodule

// File: tb/tb_mtf_tlb.sv
`timescale 1ns/1ps
module tb_mtf_tlb;
  localparam int DEPTH = 8, VPN_W = 20, CTX_W = 8, PFN_W = 20, WINDOW = 1;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic lookupValid = 1'b0, insValid = 1'b0, flush = 1'b0;
  logic [VPN_W-1:0] lookupVpn = '0, insVpn = '0;
  logic [CTX_W-1:0] lookupCtx = '0, insCtx = '0;
  logic [PFN_W-1:0] insPfn = '0;
  logic hit;
  logic [IDX_W-1:0] hitIdx;
  logic [PFN_W-1:0] hitPfn;

  int checks = 0, errors = 0;

  // Reference recency list
  logic             mValid [DEPTH];
  logic [VPN_W-1:0] mVpn   [DEPTH];
  logic [CTX_W-1:0] mCtx   [DEPTH];
  logic [PFN_W-1:0] mPfn   [DEPTH];

  always #2 clk = ~clk;

  mtf_tlb #(.DEPTH(DEPTH), .VPN_W(VPN_W), .CTX_W(CTX_W), .PFN_W(PFN_W),
            .WINDOW(WINDOW)) dut (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .lookupCtx(lookupCtx), .hit(hit), .hitIdx(hitIdx), .hitPfn(hitPfn),
    .insValid(insValid), .insVpn(insVpn), .insCtx(insCtx), .insPfn(insPfn),
    .flush(flush)
  );

  function automatic int modelFind(logic [VPN_W-1:0] v, logic [CTX_W-1:0] c);
    for (int i = 0; i < DEPTH; i++)
      if (mValid[i] && mVpn[i] == v && mCtx[i] == c) return i;
    return -1;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < DEPTH; i++) begin
      mValid[i] = 1'b0; mVpn[i] = '0; mCtx[i] = '0; mPfn[i] = '0;
    end
  endtask

  task automatic modelShift(int upto);
    for (int i = upto; i > 0; i--) begin
      mValid[i] = mValid[i-1]; mVpn[i] = mVpn[i-1];
      mCtx[i] = mCtx[i-1]; mPfn[i] = mPfn[i-1];
    end
  endtask

  task automatic check(string tag, logic lv, logic fl, logic iv,
                       logic [VPN_W-1:0] v, logic [CTX_W-1:0] c);
    int p;
    logic eHit;
    p = lv ? modelFind(v, c) : -1;
    eHit = (p >= 0);
    checks++;
    if (hit !== eHit) begin
      errors++;
      $display("FAIL %s hit actual %0b expected %0b", tag, hit, eHit);
    end else if (eHit && (int'(hitIdx) != p || hitPfn !== mPfn[p])) begin
      errors++;
      $display("FAIL %s idx/pfn actual %0d/%0h expected %0d/%0h",
               tag, hitIdx, hitPfn, p, mPfn[p]);
    end
    @(posedge clk);
    if (fl) modelClear();
    else if (iv) begin
      modelShift(DEPTH - 1);
      mValid[0] = 1'b1; mVpn[0] = insVpn; mCtx[0] = insCtx; mPfn[0] = insPfn;
    end else if (eHit && p > WINDOW) begin
      logic [VPN_W-1:0] tv; logic [CTX_W-1:0] tc; logic [PFN_W-1:0] tp;
      tv = mVpn[p]; tc = mCtx[p]; tp = mPfn[p];
      modelShift(p);
      mValid[0] = 1'b1; mVpn[0] = tv; mCtx[0] = tc; mPfn[0] = tp;
    end
  endtask

  // One cycle: drive at the falling edge, sample 1 ns later.
  task automatic step(string tag, logic lv, logic [VPN_W-1:0] v,
                      logic [CTX_W-1:0] c, logic iv, logic [VPN_W-1:0] iVpn,
                      logic [CTX_W-1:0] iCtx, logic [PFN_W-1:0] iPfn, logic fl);
    @(negedge clk);
    lookupValid = lv; lookupVpn = v; lookupCtx = c;
    insValid = iv; insVpn = iVpn; insCtx = iCtx; insPfn = iPfn; flush = fl;
    #1;
    check(tag, lv, fl, iv, v, c);
  endtask

  task automatic doInsert(string tag, int v, int c, int p);
    step(tag, 1'b0, '0, '0, 1'b1, VPN_W'(v), CTX_W'(c), PFN_W'(p), 1'b0);
  endtask

  task automatic doLookup(string tag, int v, int c);
    step(tag, 1'b1, VPN_W'(v), CTX_W'(c), 1'b0, '0, '0, '0, 1'b0);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd7321));
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10: empty after reset
    for (int k = 0; k < 4; k++) doLookup("R10", k, 0);
    // R1: no hit without lookupValid
    doInsert("R6", 5, 1, 'h505);
    step("R1", 1'b0, 5, 1, 1'b0, '0, '0, '0, 1'b0);
    doLookup("R1", 5, 2);   // context mismatch
    // Fill buffer with keys 10..17
    for (int k = 0; k < DEPTH; k++) doInsert("R6", 10 + k, 3, 'h100 + k);
    doLookup("R6", 5, 1);   // pushed out of last slot
    // R3: slot 1 and slot 0 hits stay put
    doLookup("R3", 16, 3); doLookup("R3", 16, 3); doLookup("R3", 17, 3);
    // R4 / R5: deep hit moves to front
    doLookup("R4", 12, 3); doLookup("R5", 12, 3); doLookup("R4", 17, 3);
    doLookup("R4", 10, 3); doLookup("R4", 13, 3);
    // R2: duplicate key, front copy wins
    doInsert("R6", 11, 3, 'h999);
    doLookup("R2", 11, 3);
    // R8: deep hit collides with insert
    step("R8", 1'b1, 14, 3, 1'b1, 30, 3, 'h300, 1'b0);
    doLookup("R8", 14, 3);
    // R9: flush beats insert and deep hit
    step("R9", 1'b1, 15, 3, 1'b1, 31, 3, 'h301, 1'b1);
    doLookup("R9", 31, 3);
    for (int k = 10; k < 18; k++) doLookup("R7", k, 3);
    // Eviction of invalid last slot on a partly filled list
    doInsert("R6", 40, 0, 'h40); doLookup("R6", 40, 0);

    // Random mix over a tiny key space
    for (int n = 0; n < 4000; n++) begin
      int op, v, c, p;
      string tag;
      op = $urandom_range(0, 99);
      v = $urandom_range(0, 9); c = $urandom_range(0, 1);
      p = modelFind(VPN_W'(v), CTX_W'(c));
      if (op < 2) begin
        step("R9", 1'b1, VPN_W'(v), CTX_W'(c), 1'b1, 1, 0, 'h11, 1'b1);
      end else if (op < 35) begin
        step("R6", 1'b0, '0, '0, 1'b1, VPN_W'(v), CTX_W'(c),
             PFN_W'($urandom), 1'b0);
      end else if (op < 45) begin
        step("R8", 1'b1, VPN_W'(v), CTX_W'(c), 1'b1,
             VPN_W'($urandom_range(0, 9)), CTX_W'($urandom_range(0, 1)),
             PFN_W'($urandom), 1'b0);
      end else if (op < 50) begin
        step("R1", 1'b0, VPN_W'(v), CTX_W'(c), 1'b0, '0, '0, '0, 1'b0);
      end else begin
        tag = (p > WINDOW) ? "R4" : (p >= 0) ? "R3" : "R2";
        doLookup(tag, v, c);
      end
    end
    finishRun();
  end
endmodule